// File: doc/BRIEF.md
# Low-Power Mode Wake-Up Controller

This block decides when the core of a small 8-bit controller sleeps and how it comes back. The core writes a two-bit mode word, marked by a write strobe. One bit requests idle, which stops only the core clock. The other requests power-down, which also drops the oscillator enable, so every clocked function in the block stops. While either mode is active, the block forces a fixed level onto the address-latch and program-store-enable pins.

A falling edge on any wake pin ends the low-power state. The wake pins are the serial clock and data lines and the eight lines of one port. The edge is captured by flops that need no clock. Capturing it brings the oscillator back at once, and the request is then synchronised into the restarted clock. After a power-down wake, the core stays stalled for a programmable number of oscillator cycles. It then receives a one-cycle strobe: a request to jump to the wake interrupt vector when interrupts are enabled, or an order to resume at the next instruction when they are not.

A wake flag is raised on every wake and stays set until the core reports that it has entered the service routine. A hardware reset ends any mode at once and returns the block to its run state.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the block is in run mode: `cpu_clk_en`=1, `osc_en`=1, `pin_ovr_en`=0, `wake_flag`=0, and both strobes are 0.
- R2: In run mode, a write with `reg_ctl`=2'b01 (bit 0 = idle request) enters idle at the next clock edge: `cpu_clk_en`=0, `osc_en`=1, `pin_ovr_en`=1, `pin_ovr_level`=1.
- R3: In run mode, a write with bit 1 of `reg_ctl` set (power-down request) enters power-down whatever the state of bit 0: `osc_en`=0, `cpu_clk_en`=0, `pin_ovr_en`=1, `pin_ovr_level`=0.
- R4: A write with `reg_ctl`=2'b00 leaves the block in run mode. A write made while the block is not in run mode has no effect.
- R5: A falling edge on any `wake_n` bit during power-down raises `osc_en` with no clock edge.
- R6: After a falling edge on a wake pin in idle, the wake strobe appears on the third clock edge after the pin falls (two synchroniser stages plus the mode register).
- R7: After a falling edge on a wake pin in power-down, the core stays stalled with `cpu_clk_en`=0 and the strobe appears on clock edge `stab_cycles`+4 counted from the restart of the clock.
- R8: The wake strobe lasts exactly one cycle. It is `vec_req` when `ie_en`=1 and `resume_next` when `ie_en`=0. The two are never high together.
- R9: `wake_flag` becomes 1 on the edge that ends the strobe cycle. It stays 1 until `isr_enter` is sampled high outside a strobe cycle, which clears it.
- R10: Asserting `rst_n` low during power-down raises `osc_en` at once. After release the block is in run mode with `wake_flag`=0.
- R11: Falling edges on wake pins while the block is in run mode cause no strobe and no change of mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; it stops while `osc_en` is low |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_wr | input | 1 | Write strobe for the mode word |
| reg_ctl | input | 2 | Mode word: bit 0 = idle, bit 1 = power-down |
| ie_en | input | 1 | Interrupt-enable state of the core |
| isr_enter | input | 1 | Core entered the wake service routine |
| wake_n | input | WAKE_PINS | Active-low wake pins, falling-edge sensitive |
| stab_cycles | input | CNT_W | Extra stall cycles after a power-down wake |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | Core clock enable |
| pin_ovr_en | output | 1 | Force the address-latch and store-enable pins |
| pin_ovr_level | output | 1 | Level forced on those pins (1 idle, 0 power-down) |
| vec_req | output | 1 | One-cycle jump-to-wake-vector request |
| resume_next | output | 1 | One-cycle resume-at-next-instruction order |
| wake_flag | output | 1 | Sticky wake indication |

## Verification
The assertions assume that `ie_en` is stable during the strobe cycle and that `clk` toggles whenever `osc_en` is high. They also assume that a wake pin stays low long enough to be captured and does not fall again while the block is in the same low-power state. The bench meets the clock assumption by gating its own clock with `osc_en`. It changes `ie_en` only in run mode, and it releases each wake pin only after the strobe has been seen.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

  typedef enum logic [2:0] {
    PM_RUN  = 3'd0,
    PM_IDLE = 3'd1,
    PM_DOWN = 3'd2,
    PM_STAB = 3'd3,
    PM_WAKE = 3'd4
  } pm_state_t;

  localparam int unsigned PM_IDLE_BIT = 0;
  localparam int unsigned PM_DOWN_BIT = 1;

  // Power-down request wins over idle request.
  function automatic pm_state_t pm_target(input logic [1:0] ctl);
    if (ctl[PM_DOWN_BIT])      return PM_DOWN;
    else if (ctl[PM_IDLE_BIT]) return PM_IDLE;
    else                       return PM_RUN;
  endfunction

  function automatic logic pm_is_low(input pm_state_t s);
    return (s == PM_IDLE) || (s == PM_DOWN);
  endfunction

  function automatic logic pm_core_runs(input pm_state_t s);
    return (s == PM_RUN) || (s == PM_WAKE);
  endfunction

  function automatic logic pm_timer_done(input logic active, input logic is_zero);
    return active && is_zero;
  endfunction

endpackage

// File: rtl/pwc_edge_capture.sv
module pwc_edge_capture #(
  parameter int unsigned WAKE_PINS   = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic [WAKE_PINS-1:0] wake_n,
  output logic                 cap_any,
  output logic                 req_sync
);

  logic [WAKE_PINS-1:0]   cap;
  logic [SYNC_STAGES-1:0] sync_q;

  // Clockless capture: the pin edge itself sets the flop, disarm clears it.
  for (genvar g = 0; g < WAKE_PINS; g++) begin : g_cap
    logic hit_q;
    always_ff @(negedge wake_n[g] or negedge arm) begin
      if (!arm) hit_q <= 1'b0;
      else      hit_q <= 1'b1;
    end
    assign cap[g] = hit_q;
  end

  assign cap_any = |cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sync_q <= '0;
    else if (!arm) sync_q <= '0;
    else           sync_q <= {sync_q[SYNC_STAGES-2:0], cap_any};
  end

  assign req_sync = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/pwc_stab_timer.sv
module pwc_stab_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] init,
  input  logic             active,
  output logic             done
);
  import pwr_wake_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= init;
    else if (active && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = pm_timer_done(active, cnt_q == '0);

endmodule

// File: rtl/pwc_mode_fsm.sv
module pwc_mode_fsm (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [1:0]              reg_ctl,
  input  logic                    req_sync,
  input  logic                    stab_done,
  output pwr_wake_pkg::pm_state_t state,
  output logic                    arm_q,
  output logic                    pd_q,
  output logic                    stab_load,
  output logic                    stab_active
);
  import pwr_wake_pkg::*;

  pm_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PM_RUN:  if (reg_wr)    nxt = pm_target(reg_ctl);
      PM_IDLE: if (req_sync)  nxt = PM_WAKE;
      PM_DOWN: if (req_sync)  nxt = PM_STAB;
      PM_STAB: if (stab_done) nxt = PM_WAKE;
      PM_WAKE:                nxt = PM_RUN;
      default:                nxt = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PM_RUN;
      arm_q <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      state <= nxt;
      arm_q <= pm_is_low(nxt);
      pd_q  <= (nxt == PM_DOWN);
    end
  end

  assign stab_load   = (state == PM_DOWN) && req_sync;
  assign stab_active = (state == PM_STAB);

endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl #(
  parameter int unsigned WAKE_PINS   = 10,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_ctl,
  input  logic                 ie_en,
  input  logic                 isr_enter,
  input  logic [WAKE_PINS-1:0] wake_n,
  input  logic [CNT_W-1:0]     stab_cycles,
  output logic                 osc_en,
  output logic                 cpu_clk_en,
  output logic                 pin_ovr_en,
  output logic                 pin_ovr_level,
  output logic                 vec_req,
  output logic                 resume_next,
  output logic                 wake_flag
);
  import pwr_wake_pkg::*;

  pm_state_t state;
  logic      arm_q, pd_q;
  logic      cap_any, wake_req_sync;
  logic      stab_load, stab_active, stab_done;
  logic      wake_cycle;

  pwc_edge_capture #(.WAKE_PINS(WAKE_PINS), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (arm_q),
    .wake_n   (wake_n),
    .cap_any  (cap_any),
    .req_sync (wake_req_sync)
  );

  pwc_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_ctl     (reg_ctl),
    .req_sync    (wake_req_sync),
    .stab_done   (stab_done),
    .state       (state),
    .arm_q       (arm_q),
    .pd_q        (pd_q),
    .stab_load   (stab_load),
    .stab_active (stab_active)
  );

  pwc_stab_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (stab_load),
    .init   (stab_cycles),
    .active (stab_active),
    .done   (stab_done)
  );

  assign wake_cycle = (state == PM_WAKE);

  // A captured edge restarts the oscillator without waiting for a clock.
  assign osc_en        = ~pd_q | cap_any;
  assign cpu_clk_en    = pm_core_runs(state);
  assign pin_ovr_en    = pm_is_low(state) || stab_active;
  assign pin_ovr_level = (state == PM_IDLE);
  assign vec_req       = wake_cycle & ie_en;
  assign resume_next   = wake_cycle & ~ie_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wake_flag <= 1'b0;
    else if (wake_cycle) wake_flag <= 1'b1;
    else if (isr_enter)  wake_flag <= 1'b0;
  end

endmodule

// File: rtl/pwr_wake_ctrl_sva.sv
module pwr_wake_ctrl_sva (
  input logic clk,
  input logic rst_n,
  input logic ie_en,
  input logic osc_en,
  input logic cpu_clk_en,
  input logic pin_ovr_en,
  input logic pin_ovr_level,
  input logic vec_req,
  input logic resume_next,
  input logic wake_flag,
  input logic wake_req_sync,
  input logic stab_active,
  input logic stab_done
);

  p_idle_osc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_ovr_en && pin_ovr_level) |-> (osc_en && !cpu_clk_en));

  p_core_needs_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en |-> osc_en);

  p_strobe_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req || resume_next) |-> ($past(wake_req_sync) || $past(stab_done)));

  p_stab_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stab_active |-> (osc_en && !cpu_clk_en && !vec_req && !resume_next));

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_req && resume_next));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req || resume_next) |=> !(vec_req || resume_next));

  p_vec_ie_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ie_en);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req || resume_next) |=> wake_flag);

endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_sva u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .ie_en         (ie_en),
  .osc_en        (osc_en),
  .cpu_clk_en    (cpu_clk_en),
  .pin_ovr_en    (pin_ovr_en),
  .pin_ovr_level (pin_ovr_level),
  .vec_req       (vec_req),
  .resume_next   (resume_next),
  .wake_flag     (wake_flag),
  .wake_req_sync (wake_req_sync),
  .stab_active   (stab_active),
  .stab_done     (stab_done)
);

// File: tb/pwr_wake_ctrl_test.sv
module pwr_wake_ctrl_test;
  localparam int NP = 10;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_ctl = 2'b00;
  logic          ie_en = 1'b0;
  logic          isr_enter = 1'b0;
  logic [NP-1:0] wake_n = '1;
  logic [CW-1:0] stab_cycles = '0;
  logic osc_en, cpu_clk_en, pin_ovr_en, pin_ovr_level, vec_req, resume_next, wake_flag;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  pwr_wake_ctrl #(.WAKE_PINS(NP), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_ctl(reg_ctl), .ie_en(ie_en),
    .isr_enter(isr_enter), .wake_n(wake_n), .stab_cycles(stab_cycles),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .pin_ovr_en(pin_ovr_en),
    .pin_ovr_level(pin_ovr_level), .vec_req(vec_req), .resume_next(resume_next),
    .wake_flag(wake_flag)
  );

  // 100 MHz clock that parks low while the oscillator is disabled
  always begin
    #5;
    if (clk || osc_en) clk = ~clk;
  end

  // Behavioural reference: 0 run, 1 idle, 2 power-down, 3 settling, 4 wake
  int m_state = 0, m_cnt = 0;
  bit m_s1 = 0, m_s2 = 0, m_flag = 0, m_pend = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_flag = 0; m_pend = 0;
    end else begin : upd
      int ns;
      bit low_old;
      low_old = (m_state == 1 || m_state == 2);
      ns = m_state;
      case (m_state)
        0: if (reg_wr) ns = reg_ctl[1] ? 2 : (reg_ctl[0] ? 1 : 0);
        1: if (m_s2) ns = 4;
        2: if (m_s2) ns = 3;
        3: if (m_cnt == 0) ns = 4;
        default: ns = 0;
      endcase
      if (m_state == 2 && m_s2) m_cnt = int'(stab_cycles);
      else if (m_state == 3 && m_cnt != 0) m_cnt = m_cnt - 1;
      if (m_state == 4) m_flag = 1;
      else if (isr_enter) m_flag = 0;
      m_s2 = low_old ? m_s1 : 1'b0;
      m_s1 = low_old ? m_pend : 1'b0;
      m_state = ns;
      if (!(ns == 1 || ns == 2)) m_pend = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the reference on every clock that runs
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 cpu_clk_en (model)", cpu_clk_en, (m_state == 0 || m_state == 4));
      chk("R3 osc_en (model)", osc_en, (m_state != 2) || m_pend);
      chk("R3 pin_ovr_en (model)", pin_ovr_en, (m_state == 1 || m_state == 2 || m_state == 3));
      if (pin_ovr_en) chk("R3 pin_ovr_level (model)", pin_ovr_level, (m_state == 1));
      chk("R8 vec_req (model)", vec_req, (m_state == 4) && ie_en);
      chk("R8 resume_next (model)", resume_next, (m_state == 4) && !ie_en);
      chk("R9 wake_flag (model)", wake_flag, m_flag);
    end
  end

  task automatic write_ctl(input logic [1:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_ctl = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_ctl = 2'b00;
  endtask

  task automatic drop_pin(input int i);
    wake_n[i] = 1'b0;
    if (m_state == 1 || m_state == 2) m_pend = 1;
  endtask

  task automatic wait_strobe(output int n, output bit v, output bit r);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(vec_req || resume_next) && n < 100);
    v = vec_req; r = resume_next;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    bit v, r;
    #23 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cpu_clk_en", cpu_clk_en, 1);
    chk("R1 osc_en", osc_en, 1);
    chk("R1 pin_ovr_en", pin_ovr_en, 0);
    chk("R1 wake_flag", wake_flag, 0);
    chk("R1 strobes", vec_req | resume_next, 0);

    // R4 empty write stays in run
    write_ctl(2'b00);
    chk("R4 run after 00 write", cpu_clk_en, 1);

    // R2 idle entry
    ie_en = 1'b1;
    write_ctl(2'b01);
    chk("R2 idle cpu_clk_en", cpu_clk_en, 0);
    chk("R2 idle osc_en", osc_en, 1);
    chk("R2 idle ovr level", pin_ovr_level, 1);
    // R4 write ignored while idle
    write_ctl(2'b10);
    chk("R4 write in idle ignored osc", osc_en, 1);
    chk("R4 write in idle ignored lvl", pin_ovr_level, 1);

    // R6 idle wake by port pin
    drop_pin(3);
    wait_strobe(n, v, r);
    chk("R6 idle wake latency", n, 3);
    chk("R8 vec_req with ie", v, 1);
    chk("R8 no resume with ie", r, 0);
    wake_n[3] = 1'b1;
    @(negedge clk);
    chk("R8 strobe one cycle", vec_req | resume_next, 0);
    chk("R9 flag set", wake_flag, 1);
    isr_enter = 1'b1;
    @(negedge clk);
    isr_enter = 1'b0;
    chk("R9 flag cleared by isr", wake_flag, 0);

    // R3 power-down, interrupts off, R7 settle of 3
    ie_en = 1'b0;
    stab_cycles = 8'd3;
    write_ctl(2'b10);
    #40;
    chk("R3 pd osc_en", osc_en, 0);
    chk("R3 pd cpu_clk_en", cpu_clk_en, 0);
    chk("R3 pd ovr level", pin_ovr_level, 0);
    drop_pin(0);
    #1;
    chk("R5 osc restarts without clock", osc_en, 1);
    wait_strobe(n, v, r);
    chk("R7 pd wake latency 3", n, 7);
    chk("R8 resume without ie", r, 1);
    chk("R8 no vec without ie", v, 0);
    wake_n[0] = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 flag held with no isr", wake_flag, 1);

    // R3 both bits: power-down wins; R7 settle of 0
    ie_en = 1'b1;
    stab_cycles = 8'd0;
    write_ctl(2'b11);
    #40;
    chk("R3 priority osc_en", osc_en, 0);
    chk("R3 priority ovr level", pin_ovr_level, 0);
    drop_pin(9);
    wait_strobe(n, v, r);
    chk("R7 pd wake latency 0", n, 4);
    chk("R8 vec after pd", v, 1);
    wake_n[9] = 1'b1;

    // R11 edge in run is ignored
    @(negedge clk);
    drop_pin(5);
    n = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (vec_req || resume_next || !cpu_clk_en) n++;
    end
    chk("R11 no wake in run", n, 0);
    wake_n[5] = 1'b1;

    // R10 reset ends power-down (flag is set at this point)
    chk("R10 flag set before", wake_flag, 1);
    write_ctl(2'b10);
    #40;
    chk("R10 pd before reset", osc_en, 0);
    rst_n = 1'b0;
    #3;
    chk("R10 osc on reset", osc_en, 1);
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 run after reset", cpu_clk_en, 1);
    chk("R10 flag cleared", wake_flag, 0);
    chk("R10 no override", pin_ovr_en, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule